// File: doc/BRIEF.md
# Extension Slot Decode and Control Unit

This unit sits beside a processor pipeline and manages a set of extension slots, eight by default. Each slot has a 32-bit control word, a hit counter and a miss counter. The processor reaches all three through a system-register port. A register-kind code picks which of the three is accessed, and a slot select picks the slot. Counter reads are destructive: the access returns the count and zeroes it.

Every control word also acts as one entry of a decode CAM. The entry opcode sits in bits 31:26. The entry is valid only while the loaded flag (bit 0) is set. Writing the control word reprograms the entry, and the next instruction sees the change.

On each incoming instruction the unit compares the major opcode with all valid entries. Among the matching slots that are also enabled, it picks the one with the highest priority. If no enabled slot matches, a matching disabled slot with its trap-enable flag set raises a reserved-instruction trap. If no such slot exists, the instruction falls through to normal decoding. An enabled slot may reuse a base opcode, and then it takes that instruction over.

Top module: `ext_slot_ctrl`

## Requirements
- R1: After reset every control word, hit counter and miss counter reads zero, and no instruction hits or traps.
- R2: A control write (kind 0) stores the full 32-bit value. During the write cycle `csr_rdata_o` presents the value the word held before the write.
- R3: An entry matches when bit 0 (loaded) is set and bits 31:26 equal the instruction opcode. A rewritten entry takes effect on the very next decode. A slot with bit 0 clear never matches.
- R4: Among matching slots with bit 1 (enable) set, the highest value in bits 11:8 wins. On equal priority the lowest slot index wins. The winner is reported on `dec_hit_o` and `dec_slot_o`.
- R5: If no enabled slot matches, the lowest-index matching slot with bit 4 (trap-enable) set raises `dec_trap_o` and is named on `dec_slot_o`. Bit 3 (trapped) of that slot is set at the next clock edge.
- R6: A matching slot that is disabled and has bit 4 clear causes neither hit nor trap. `dec_slot_o` then reads 0.
- R7: Each dispatched instruction increments the hit counter (kind 1) of the winning slot.
- R8: Each matching slot that is not the winner increments its miss counter (kind 2). This includes a slot that traps.
- R9: A read of a hit or miss counter returns its value and clears it. If the same counter is incremented in that same cycle, it holds 1 afterwards.
- R10: Counters saturate at all ones.
- R11: Software clears the trapped bit by writing the control word with bit 3 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_en_i | input | 1 | System-register access valid |
| csr_we_i | input | 1 | Access is a write |
| csr_reg_i | input | 2 | Register kind: 0 control, 1 hit counter, 2 miss counter, 3 none (reads 0) |
| csr_sel_i | input | SEL_W | Slot select |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data (combinational, counters zero-extended) |
| dec_valid_i | input | 1 | Instruction presented for decode |
| dec_op_i | input | 6 | Major opcode of the instruction |
| dec_hit_o | output | 1 | An enabled slot claims the instruction |
| dec_trap_o | output | 1 | Reserved-instruction trap |
| dec_slot_o | output | SEL_W | Winning or trapping slot |

## Verification
The bench loads a mix of entries: two equal-priority enabled slots on one opcode, a disabled slot that traps, a disabled slot that does not trap, and an enabled slot that is not loaded. It then decodes each opcode and checks the result. A design with the tie-break reversed would report slot 2 where slot 1 is expected. A design that trapped regardless of the trap-enable flag would raise a trap on the fall-through opcode. A design that skipped the loaded check would hit on the unloaded slot. Further tests hit a counter in the same cycle it is read, which catches a design that loses that count. They drive one counter past its limit, which catches a design that wraps to zero. They read a control word while writing it, which catches a design that returns the new value.

// File: rtl/ext_slot_pkg.sv
package ext_slot_pkg;
  localparam int XLEN      = 32;
  localparam int OP_W      = 6;
  localparam int OP_LSB    = 26;
  localparam int PRI_LSB   = 8;
  localparam int PRI_W     = 4;
  localparam int B_TRAPEN  = 4;
  localparam int B_TRAPPED = 3;
  localparam int B_EN      = 1;
  localparam int B_LD      = 0;

  typedef enum logic [1:0] {
    CSR_CTL  = 2'd0,
    CSR_HIT  = 2'd1,
    CSR_MISS = 2'd2,
    CSR_NONE = 2'd3
  } csr_kind_e;
endpackage

// File: rtl/ext_slot_cam.sv
module ext_slot_cam
  import ext_slot_pkg::*;
#(
  parameter int N_SLOTS = 8
) (
  input  logic [N_SLOTS-1:0][XLEN-1:0] ctl_i,
  input  logic                         valid_i,
  input  logic [OP_W-1:0]              op_i,
  output logic [N_SLOTS-1:0]           match_o,
  output logic [N_SLOTS-1:0]           live_o,
  output logic [N_SLOTS-1:0]           trapen_o
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_ent
    assign match_o[g]  = valid_i && ctl_i[g][B_LD] && (ctl_i[g][OP_LSB +: OP_W] == op_i);
    assign live_o[g]   = match_o[g] && ctl_i[g][B_EN];
    assign trapen_o[g] = ctl_i[g][B_TRAPEN];
  end
endmodule

// File: rtl/ext_slot_arb.sv
module ext_slot_arb
  import ext_slot_pkg::*;
#(
  parameter int N_SLOTS = 8,
  localparam int SEL_W  = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0]            match_i,
  input  logic [N_SLOTS-1:0]            live_i,
  input  logic [N_SLOTS-1:0]            trapen_i,
  input  logic [N_SLOTS-1:0][PRI_W-1:0] pri_i,
  output logic                          hit_o,
  output logic                          trap_o,
  output logic [SEL_W-1:0]              slot_o,
  output logic [N_SLOTS-1:0]            grant_o
);
  logic [PRI_W-1:0] best_pri;
  logic [SEL_W-1:0] best_idx;
  logic             found;
  logic [SEL_W-1:0] trap_idx;
  logic             trap_found;

  always_comb begin
    found    = 1'b0;
    best_pri = '0;
    best_idx = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      // strict compare keeps the lower index on a tie
      if (live_i[i] && (!found || pri_i[i] > best_pri)) begin
        found    = 1'b1;
        best_pri = pri_i[i];
        best_idx = SEL_W'(i);
      end
    end
  end

  always_comb begin
    trap_found = 1'b0;
    trap_idx   = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (match_i[i] && !live_i[i] && trapen_i[i]) begin
        trap_found = 1'b1;
        trap_idx   = SEL_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (found) grant_o[best_idx] = 1'b1;
  end

  assign hit_o  = found;
  assign trap_o = !found && trap_found;
  assign slot_o = found ? best_idx : (trap_found ? trap_idx : '0);
endmodule

// File: rtl/ext_sat_cnt.sv
module ext_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= inc_i ? CNT_W'(1) : '0;
    end else if (inc_i && cnt_o != '1) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ext_slot_ctrl.sv
module ext_slot_ctrl
  import ext_slot_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = $clog2(N_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_en_i,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_reg_i,
  input  logic [SEL_W-1:0] csr_sel_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic             dec_valid_i,
  input  logic [OP_W-1:0]  dec_op_i,
  output logic             dec_hit_o,
  output logic             dec_trap_o,
  output logic [SEL_W-1:0] dec_slot_o
);
  csr_kind_e kind;
  assign kind = csr_kind_e'(csr_reg_i);

  logic [N_SLOTS-1:0][XLEN-1:0]  ctl_q;
  logic [N_SLOTS-1:0][CNT_W-1:0] hit_q;
  logic [N_SLOTS-1:0][CNT_W-1:0] miss_q;
  logic [N_SLOTS-1:0][PRI_W-1:0] pri;
  logic [N_SLOTS-1:0]            match, live, trapen, grant;

  ext_slot_cam #(.N_SLOTS(N_SLOTS)) u_cam (
    .ctl_i    (ctl_q),
    .valid_i  (dec_valid_i),
    .op_i     (dec_op_i),
    .match_o  (match),
    .live_o   (live),
    .trapen_o (trapen)
  );

  ext_slot_arb #(.N_SLOTS(N_SLOTS)) u_arb (
    .match_i  (match),
    .live_i   (live),
    .trapen_i (trapen),
    .pri_i    (pri),
    .hit_o    (dec_hit_o),
    .trap_o   (dec_trap_o),
    .slot_o   (dec_slot_o),
    .grant_o  (grant)
  );

  logic rd_acc, wr_acc;
  assign rd_acc = csr_en_i && !csr_we_i;
  assign wr_acc = csr_en_i &&  csr_we_i;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic sel_me, wr_ctl, set_td;
    assign sel_me = (csr_sel_i == SEL_W'(g));
    assign wr_ctl = wr_acc && kind == CSR_CTL && sel_me;
    assign set_td = dec_trap_o && dec_slot_o == SEL_W'(g);
    assign pri[g] = ctl_q[g][PRI_LSB +: PRI_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[g] <= '0;
      end else if (wr_ctl) begin
        ctl_q[g] <= csr_wdata_i;
      end else if (set_td) begin
        ctl_q[g][B_TRAPPED] <= 1'b1;
      end
    end

    ext_sat_cnt #(.CNT_W(CNT_W)) u_hit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (grant[g]),
      .clr_i  (rd_acc && kind == CSR_HIT && sel_me),
      .cnt_o  (hit_q[g])
    );

    ext_sat_cnt #(.CNT_W(CNT_W)) u_miss (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (match[g] && !grant[g]),
      .clr_i  (rd_acc && kind == CSR_MISS && sel_me),
      .cnt_o  (miss_q[g])
    );
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_en_i) begin
      unique case (kind)
        CSR_CTL:  csr_rdata_o = ctl_q[csr_sel_i];
        CSR_HIT:  csr_rdata_o = XLEN'(hit_q[csr_sel_i]);
        CSR_MISS: csr_rdata_o = XLEN'(miss_q[csr_sel_i]);
        default:  csr_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ext_slot_ctrl_chk.sv
module ext_slot_ctrl_chk
  import ext_slot_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CNT_W   = 32,
  localparam int SEL_W  = $clog2(N_SLOTS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          csr_en_i,
  input logic                          csr_we_i,
  input logic [1:0]                    csr_reg_i,
  input logic [SEL_W-1:0]              csr_sel_i,
  input logic                          dec_valid_i,
  input logic [OP_W-1:0]               dec_op_i,
  input logic                          dec_hit_o,
  input logic                          dec_trap_o,
  input logic [SEL_W-1:0]              dec_slot_o,
  input logic [N_SLOTS-1:0][XLEN-1:0]  ctl_q,
  input logic [N_SLOTS-1:0][CNT_W-1:0] hit_q
);
  AST_HIT_IS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit_o |-> dec_valid_i && ctl_q[dec_slot_o][B_LD] && ctl_q[dec_slot_o][B_EN]
                  && ctl_q[dec_slot_o][OP_LSB +: OP_W] == dec_op_i); // R3

  AST_HIT_TRAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_hit_o && dec_trap_o)); // R5

  AST_TRAP_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_trap_o && !(csr_en_i && csr_we_i && csr_reg_i == 2'd0 && csr_sel_i == dec_slot_o))
    |=> ctl_q[$past(dec_slot_o)][B_TRAPPED]); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && !csr_we_i && csr_reg_i == 2'd1
     && !(dec_hit_o && dec_slot_o == csr_sel_i))
    |=> hit_q[$past(csr_sel_i)] == '0); // R9

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_sat
    AST_HIT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_q[g] == '1 && !(csr_en_i && !csr_we_i && csr_reg_i == 2'd1
                           && csr_sel_i == SEL_W'(g)))
      |=> hit_q[g] == '1); // R10
  end
endmodule

bind ext_slot_ctrl ext_slot_ctrl_chk #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_en_i    (csr_en_i),
  .csr_we_i    (csr_we_i),
  .csr_reg_i   (csr_reg_i),
  .csr_sel_i   (csr_sel_i),
  .dec_valid_i (dec_valid_i),
  .dec_op_i    (dec_op_i),
  .dec_hit_o   (dec_hit_o),
  .dec_trap_o  (dec_trap_o),
  .dec_slot_o  (dec_slot_o),
  .ctl_q       (ctl_q),
  .hit_q       (hit_q)
);

// File: tb/ext_slot_ctrl_bench.sv
module ext_slot_ctrl_bench;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0, csr_we = 1'b0;
  logic [1:0]  csr_reg = 2'd0;
  logic [2:0]  csr_sel = 3'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        dec_valid = 1'b0;
  logic [5:0]  dec_op = '0;
  logic        dec_hit, dec_trap;
  logic [2:0]  dec_slot;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ext_slot_ctrl #(.N_SLOTS(8), .CNT_W(CW)) u_ext_slot_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_en_i(csr_en), .csr_we_i(csr_we), .csr_reg_i(csr_reg),
    .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .dec_valid_i(dec_valid), .dec_op_i(dec_op),
    .dec_hit_o(dec_hit), .dec_trap_o(dec_trap), .dec_slot_o(dec_slot)
  );

  typedef struct packed {
    logic [5:0] op;
    logic       hit;
    logic       trap;
    logic [2:0] slot;
  } vec_t;

  // R3 R4 R5 R6 decode table against the configuration loaded below
  localparam vec_t VEC [7] = '{
    '{op: 6'h02, hit: 1'b1, trap: 1'b0, slot: 3'd1},
    '{op: 6'h05, hit: 1'b0, trap: 1'b1, slot: 3'd3},
    '{op: 6'h06, hit: 1'b0, trap: 1'b0, slot: 3'd0},
    '{op: 6'h07, hit: 1'b0, trap: 1'b0, slot: 3'd0},
    '{op: 6'h08, hit: 1'b1, trap: 1'b0, slot: 3'd6},
    '{op: 6'h00, hit: 1'b0, trap: 1'b0, slot: 3'd0},
    '{op: 6'h03, hit: 1'b0, trap: 1'b0, slot: 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_reg = 2'd0; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] kind, input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_reg = kind; csr_sel = sel;
    #1 d = csr_rdata;
    @(negedge clk);
    csr_en = 1'b0;
  endtask

  task automatic decode(input logic [5:0] op, output logic h, output logic t, output logic [2:0] s);
    @(negedge clk);
    dec_valid = 1'b1; dec_op = op;
    #1 h = dec_hit; t = dec_trap; s = dec_slot;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic h, t;
    logic [2:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      csr_rd(2'd0, 3'(i), d); chk("R1 ctl", d, 32'h0);
    end
    csr_rd(2'd1, 3'd0, d); chk("R1 hit", d, 32'h0);
    csr_rd(2'd2, 3'd7, d); chk("R1 miss", d, 32'h0);
    decode(6'h00, h, t, s); chk("R1 decode", {h, t}, 2'b00);

    // configuration: ctl = op<<26 | pri<<8 | flags (bit4 trap-en, bit1 en, bit0 loaded)
    csr_wr(3'd0, 32'h0800_0103);
    csr_wr(3'd1, 32'h0800_0303);
    csr_wr(3'd2, 32'h0800_0303);
    csr_wr(3'd3, 32'h1400_0011);
    csr_wr(3'd4, 32'h1800_0001);
    csr_wr(3'd5, 32'h1C00_0002);
    csr_wr(3'd6, 32'h2000_0013);
    csr_rd(2'd0, 3'd6, d); chk("R2 ctl store", d, 32'h2000_0013);

    for (int v = 0; v < 7; v++) begin
      decode(VEC[v].op, h, t, s);
      chk($sformatf("R4/R5/R6 vec%0d", v), {29'd0, h, t, s[0]}, {29'd0, VEC[v].hit, VEC[v].trap, VEC[v].slot[0]});
      chk($sformatf("R4 slot vec%0d", v), {29'd0, s}, {29'd0, VEC[v].slot});
    end

    // R5 trapped bit set, R11 cleared by software
    csr_rd(2'd0, 3'd3, d); chk("R5 trapped set", d, 32'h1400_0019);
    csr_wr(3'd3, 32'h1400_0011);
    csr_rd(2'd0, 3'd3, d); chk("R11 trapped clear", d, 32'h1400_0011);

    // R7 hit counter, R9 clear on read
    csr_rd(2'd1, 3'd1, d); chk("R7 hit slot1", d, 32'd1);
    csr_rd(2'd1, 3'd1, d); chk("R9 cleared", d, 32'd0);
    csr_rd(2'd1, 3'd2, d); chk("R7 tie loser no hit", d, 32'd0);
    // R8 miss counters
    csr_rd(2'd2, 3'd0, d); chk("R8 miss slot0", d, 32'd1);
    csr_rd(2'd2, 3'd2, d); chk("R8 miss slot2", d, 32'd1);
    csr_rd(2'd2, 3'd3, d); chk("R8 miss trap slot3", d, 32'd1);
    csr_rd(2'd2, 3'd4, d); chk("R8 miss slot4", d, 32'd1);
    csr_rd(2'd2, 3'd5, d); chk("R8 unloaded no miss", d, 32'd0);

    // R9 read and increment in the same cycle
    @(negedge clk);
    dec_valid = 1'b1; dec_op = 6'h08;
    csr_en = 1'b1; csr_we = 1'b0; csr_reg = 2'd1; csr_sel = 3'd6;
    #1 chk("R9 read during inc", csr_rdata, 32'd1);
    @(negedge clk);
    dec_valid = 1'b0; csr_en = 1'b0;
    csr_rd(2'd1, 3'd6, d); chk("R9 inc kept", d, 32'd1);
    csr_rd(2'd1, 3'd6, d); chk("R9 then zero", d, 32'd0);

    // R10 saturation
    for (int k = 0; k < 20; k++) decode(6'h08, h, t, s);
    csr_rd(2'd1, 3'd6, d); chk("R10 saturate", d, 32'd15);

    // R2 read old value during write
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_reg = 2'd0; csr_sel = 3'd5; csr_wdata = 32'hABCD_0000;
    #1 chk("R2 old value", csr_rdata, 32'h1C00_0002);
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
    csr_rd(2'd0, 3'd5, d); chk("R2 new value", d, 32'hABCD_0000);

    // R3 live reprogram of slot7 to opcode 3
    csr_wr(3'd7, 32'h0C00_0003);
    decode(6'h03, h, t, s); chk("R3 reprogram", {28'd0, h, s}, {28'd0, 1'b1, 3'd7});

    // R4 raise slot0 priority to 15, then R8 loser misses
    csr_wr(3'd0, 32'h0800_0F03);
    decode(6'h02, h, t, s); chk("R4 priority", {28'd0, h, s}, {28'd0, 1'b1, 3'd0});
    csr_rd(2'd2, 3'd1, d); chk("R8 loser slot1", d, 32'd1);

    // R6 disabled trap-enable cleared: write slot6 without enable or trap-enable
    csr_wr(3'd6, 32'h2000_0001);
    decode(6'h08, h, t, s); chk("R6 fall through", {29'd0, h, t, s[0]}, 32'd0);

    // R3 clearing loaded removes the entry
    csr_wr(3'd7, 32'h0C00_0002);
    decode(6'h03, h, t, s); chk("R3 unloaded", {30'd0, h, t}, 32'd0);

    finish_run();
  end
endmodule